// File: doc/BRIEF.md
# ATA Command Snooping Bus Controller

This block sits on the path between a host-side parallel task-file interface and an ATA disk drive, and decides who owns the drive's data bus. While no Ultra DMA command is in flight it selects pass-through routing. Every host register read and write then reaches the drive unchanged, and the block itself touches none of that traffic.

The block snoops the host's register writes. Only a write that targets the command register counts. If its opcode is one of the Ultra DMA read or Ultra DMA write codes, the bus is handed to the matching processing pipeline. It returns to pass-through when that pipeline raises its done flag. The outputs are three one-hot bus-ownership selects and a two-bit mode code. The surrounding fabric uses them to steer its multiplexers. The inputs are assumed to be synchronous to the block clock.

Top module: `ata_cmd_snoop`

## Requirements
- R1: While the synchronous reset is high, and on the first sample after it is released, the mode is pass-through: mode = 0, sel_pio = 1, sel_rd_pipe = 0, sel_wr_pipe = 0.
- R2: The mode is encoded as 0 for pass-through, 1 for DMA read and 2 for DMA write. Exactly one select is high at all times, and it matches the mode: sel_pio for 0, sel_rd_pipe for 1, sel_wr_pipe for 2.
- R3: A host write of 0xC8 or 0x25 to the command register, made while in pass-through, switches to DMA read. The command register is address 7 with host_cs0_n low and host_cs1_n high. The opcode is carried on host_dat[7:0]. The new mode appears on the second clock edge after the edge that first samples host_wr_n high again.
- R4: A host write of 0xCA or 0x35 to the command register, made while in pass-through, switches to DMA write, with the same timing as R3.
- R5: Any other opcode written to the command register leaves the block in pass-through.
- R6: A DMA opcode written anywhere other than the command register has no effect. This covers another address, host_cs0_n high, and host_cs1_n low.
- R7: The opcode that counts is the one sampled at the last clock edge at which host_wr_n was still low. Earlier values during the same strobe, and values present once the strobe is high, are not used.
- R8: In DMA read, rd_done high at a clock edge returns the block to pass-through at that edge. wr_done is ignored in this mode.
- R9: In DMA write, wr_done high at a clock edge returns the block to pass-through at that edge. rd_done is ignored in this mode.
- R10: Command-register writes made while in either DMA mode do not change the mode, even if they carry DMA opcodes.
- R11: rd_done and wr_done have no effect while in pass-through.
- R12: Raising the synchronous reset while in a DMA mode returns the block to pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Host task-file register address |
| host_cs0_n | input | 1 | Command-block chip select, active low |
| host_cs1_n | input | 1 | Control-block chip select, active low |
| host_wr_n | input | 1 | Host register write strobe, active low |
| host_dat | input | 8 | Low byte of the host data bus (command opcode lane) |
| rd_done | input | 1 | Read pipeline reports its transfer is complete |
| wr_done | input | 1 | Write pipeline reports its transfer is complete |
| sel_pio | output | 1 | Pass-through routing owns the bus |
| sel_rd_pipe | output | 1 | Read pipeline owns the bus |
| sel_wr_pipe | output | 1 | Write pipeline owns the bus |
| mode | output | 2 | Current mode code (0 pass-through, 1 DMA read, 2 DMA write) |

## Verification
The bench builds the block with its default parameters. That means a three-bit address with the command register at 7, and two opcodes per direction, so the generate loops in the decoder compare against both entries of each list. With these values the bench can reach:
- every opcode in both lists, plus near-miss opcodes;
- writes that fail only one of the three command-register qualifiers;
- strobes held low across several opcode values;
- done flags raised in every mode, including the wrong one.

// File: rtl/ata_snoop_pkg.sv
package ata_snoop_pkg;

    localparam int OP_W = 8;

    typedef enum logic [1:0] {
        MODE_PIO    = 2'd0,
        MODE_DMA_RD = 2'd1,
        MODE_DMA_WR = 2'd2
    } bus_mode_e;

    typedef struct packed {
        bus_mode_e mode;
    } fsm_state_t;

endpackage

// File: rtl/ata_cmd_capture.sv
module ata_cmd_capture
    import ata_snoop_pkg::*;
#(
    parameter int                ADDR_W   = 3,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 3'd7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic              wr_n,
    input  logic [OP_W-1:0]   dat,
    output logic              evt_valid,
    output logic [OP_W-1:0]   evt_op
);

    typedef struct packed {
        logic              wr_n;
        logic [ADDR_W-1:0] addr;
        logic              cs0_n;
        logic              cs1_n;
        logic [OP_W-1:0]   op;
        logic              evt;
        logic [OP_W-1:0]   evt_op;
    } cap_t;

    cap_t cap_d, cap_q;
    logic strobe_rise;
    logic cmd_reg_hit;

    always_comb begin
        // Rising edge of the strobe: high now, low at the previous edge.
        strobe_rise = wr_n & ~cap_q.wr_n;
        // Address and chip selects as they stood while the strobe was low.
        cmd_reg_hit = ~cap_q.cs0_n & cap_q.cs1_n & (cap_q.addr == CMD_ADDR);

        cap_d        = cap_q;
        cap_d.wr_n   = wr_n;
        cap_d.addr   = addr;
        cap_d.cs0_n  = cs0_n;
        cap_d.cs1_n  = cs1_n;
        cap_d.op     = dat;
        cap_d.evt    = strobe_rise & cmd_reg_hit;
        cap_d.evt_op = cap_q.op;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '{wr_n: 1'b1, addr: '0, cs0_n: 1'b1, cs1_n: 1'b1,
                       op: '0, evt: 1'b0, evt_op: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign evt_valid = cap_q.evt;
    assign evt_op    = cap_q.evt_op;

endmodule

// File: rtl/ata_opcode_decode.sv
module ata_opcode_decode
    import ata_snoop_pkg::*;
#(
    parameter int                   N_RD   = 2,
    parameter logic [N_RD*OP_W-1:0] RD_OPS = 16'h25C8,
    parameter int                   N_WR   = 2,
    parameter logic [N_WR*OP_W-1:0] WR_OPS = 16'h35CA
) (
    input  logic [OP_W-1:0] op,
    output logic            is_rd,
    output logic            is_wr
);

    logic [N_RD-1:0] rd_match;
    logic [N_WR-1:0] wr_match;

    for (genvar gi = 0; gi < N_RD; gi++) begin : g_rd
        assign rd_match[gi] = (op == RD_OPS[gi*OP_W +: OP_W]);
    end

    for (genvar gj = 0; gj < N_WR; gj++) begin : g_wr
        assign wr_match[gj] = (op == WR_OPS[gj*OP_W +: OP_W]);
    end

    // If the lists ever overlap, the read direction wins.
    assign is_rd = |rd_match;
    assign is_wr = (|wr_match) & ~is_rd;

endmodule

// File: rtl/ata_mode_fsm.sv
module ata_mode_fsm
    import ata_snoop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt_valid,
    input  logic      is_rd,
    input  logic      is_wr,
    input  logic      rd_done,
    input  logic      wr_done,
    output bus_mode_e mode
);

    fsm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_PIO: begin
                if (evt_valid && is_rd) begin
                    st_d.mode = MODE_DMA_RD;
                end else if (evt_valid && is_wr) begin
                    st_d.mode = MODE_DMA_WR;
                end
            end
            MODE_DMA_RD: begin
                if (rd_done) st_d.mode = MODE_PIO;
            end
            MODE_DMA_WR: begin
                if (wr_done) st_d.mode = MODE_PIO;
            end
            default: st_d.mode = MODE_PIO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: MODE_PIO};
        else     st_q <= st_d;
    end

    assign mode = st_q.mode;

endmodule

// File: rtl/ata_cmd_snoop.sv
module ata_cmd_snoop
    import ata_snoop_pkg::*;
#(
    parameter int                   ADDR_W   = 3,
    parameter logic [ADDR_W-1:0]    CMD_ADDR = 3'd7,
    parameter int                   N_RD     = 2,
    parameter logic [N_RD*OP_W-1:0] RD_OPS   = 16'h25C8,
    parameter int                   N_WR     = 2,
    parameter logic [N_WR*OP_W-1:0] WR_OPS   = 16'h35CA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_cs0_n,
    input  logic              host_cs1_n,
    input  logic              host_wr_n,
    input  logic [OP_W-1:0]   host_dat,
    input  logic              rd_done,
    input  logic              wr_done,
    output logic              sel_pio,
    output logic              sel_rd_pipe,
    output logic              sel_wr_pipe,
    output logic [1:0]        mode
);

    logic            evt_valid;
    logic [OP_W-1:0] evt_op;
    logic            is_rd;
    logic            is_wr;
    bus_mode_e       cur_mode;

    ata_cmd_capture #(
        .ADDR_W   (ADDR_W),
        .CMD_ADDR (CMD_ADDR)
    ) i_capture (
        .clk       (clk),
        .rst       (rst),
        .addr      (host_addr),
        .cs0_n     (host_cs0_n),
        .cs1_n     (host_cs1_n),
        .wr_n      (host_wr_n),
        .dat       (host_dat),
        .evt_valid (evt_valid),
        .evt_op    (evt_op)
    );

    ata_opcode_decode #(
        .N_RD   (N_RD),
        .RD_OPS (RD_OPS),
        .N_WR   (N_WR),
        .WR_OPS (WR_OPS)
    ) i_decode (
        .op    (evt_op),
        .is_rd (is_rd),
        .is_wr (is_wr)
    );

    ata_mode_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .is_rd     (is_rd),
        .is_wr     (is_wr),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .mode      (cur_mode)
    );

    always_comb begin
        sel_pio     = (cur_mode == MODE_PIO);
        sel_rd_pipe = (cur_mode == MODE_DMA_RD);
        sel_wr_pipe = (cur_mode == MODE_DMA_WR);
        mode        = cur_mode;
    end

endmodule

// File: rtl/ata_cmd_snoop_chk.sv
module ata_cmd_snoop_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_done,
    input logic       wr_done,
    input logic       sel_pio,
    input logic       sel_rd_pipe,
    input logic       sel_wr_pipe,
    input logic [1:0] mode
);

    // R2: exactly one owner at any time
    p_one_owner_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({sel_pio, sel_rd_pipe, sel_wr_pipe}) == 1);

    // R2: select agrees with the mode code
    p_sel_mode_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> sel_pio);

    // R3: read ownership is only taken from pass-through
    p_rd_from_pio_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_rd_pipe) |-> $past(sel_pio));

    // R4: write ownership is only taken from pass-through
    p_wr_from_pio_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_wr_pipe) |-> $past(sel_pio));

    // R8: read done releases the bus
    p_rd_release_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && rd_done) |=> (mode == 2'd0));

    // R9: write done releases the bus
    p_wr_release_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && wr_done) |=> (mode == 2'd0));

    // R10: read ownership holds until its own done
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && !rd_done) |=> (mode == 2'd1));

    // R10: write ownership holds until its own done
    p_wr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && !wr_done) |=> (mode == 2'd2));

endmodule

bind ata_cmd_snoop ata_cmd_snoop_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_done     (rd_done),
    .wr_done     (wr_done),
    .sel_pio     (sel_pio),
    .sel_rd_pipe (sel_rd_pipe),
    .sel_wr_pipe (sel_wr_pipe),
    .mode        (mode)
);

// File: tb/test_ata_cmd_snoop.sv
module test_ata_cmd_snoop;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] host_addr;
    logic       host_cs0_n;
    logic       host_cs1_n;
    logic       host_wr_n;
    logic [7:0] host_dat;
    logic       rd_done;
    logic       wr_done;
    logic       sel_pio;
    logic       sel_rd_pipe;
    logic       sel_wr_pipe;
    logic [1:0] mode;

    int errors = 0;
    int checks = 0;

    logic [1:0] exp_mode_q[$];
    string      exp_tag_q[$];
    event       do_sample;

    always #5 clk = ~clk;

    ata_cmd_snoop i_ata_cmd_snoop (
        .clk         (clk),
        .rst         (rst),
        .host_addr   (host_addr),
        .host_cs0_n  (host_cs0_n),
        .host_cs1_n  (host_cs1_n),
        .host_wr_n   (host_wr_n),
        .host_dat    (host_dat),
        .rd_done     (rd_done),
        .wr_done     (wr_done),
        .sel_pio     (sel_pio),
        .sel_rd_pipe (sel_rd_pipe),
        .sel_wr_pipe (sel_wr_pipe),
        .mode        (mode)
    );

    // Monitor: pops one expected item per sample request and compares.
    initial begin
        forever begin
            @(do_sample);
            #1;
            while (exp_mode_q.size() > 0) begin
                logic [1:0] em;
                string      tg;
                logic [2:0] got_sel;
                logic [2:0] exp_sel;
                em = exp_mode_q.pop_front();
                tg = exp_tag_q.pop_front();
                got_sel = {sel_wr_pipe, sel_rd_pipe, sel_pio};
                exp_sel = {em == 2'd2, em == 2'd1, em == 2'd0};
                checks++;
                if (mode !== em || got_sel !== exp_sel) begin
                    errors++;
                    $display("FAIL %s: mode=%0d sel=%b expected mode=%0d sel=%b",
                             tg, mode, got_sel, em, exp_sel);
                end
            end
        end
    end

    task automatic expect_mode(input logic [1:0] m, input string tag);
        exp_mode_q.push_back(m);
        exp_tag_q.push_back(tag);
        -> do_sample;
        @(negedge clk);
    endtask

    task automatic bus_idle();
        host_addr  = 3'd0;
        host_cs0_n = 1'b1;
        host_cs1_n = 1'b1;
        host_wr_n  = 1'b1;
        host_dat   = 8'h00;
    endtask

    // One-cycle-low register write; returns at the sample point of R3 timing.
    task automatic reg_write(input logic [2:0] a, input logic c0, input logic c1,
                             input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_cs0_n = c0; host_cs1_n = c1; host_dat = d;
        host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_idle();
    endtask

    task automatic pulse_done(input logic r, input logic w);
        @(negedge clk);
        rd_done = r; wr_done = w;
        @(negedge clk);
        rd_done = 1'b0; wr_done = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; rd_done = 1'b0; wr_done = 1'b0;
        bus_idle();
        repeat (3) @(negedge clk);
        expect_mode(2'd0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        expect_mode(2'd0, "R1 after reset");

        // R11: done flags in pass-through
        pulse_done(1'b1, 1'b1);
        expect_mode(2'd0, "R11 done in pio");

        // R5: non-DMA opcodes
        reg_write(3'd7, 1'b0, 1'b1, 8'hEC);
        expect_mode(2'd0, "R5 opcode EC");
        reg_write(3'd7, 1'b0, 1'b1, 8'hC9);
        expect_mode(2'd0, "R5 opcode C9");

        // R6: wrong address / chip selects
        reg_write(3'd6, 1'b0, 1'b1, 8'hC8);
        expect_mode(2'd0, "R6 addr 6");
        reg_write(3'd7, 1'b1, 1'b1, 8'hC8);
        expect_mode(2'd0, "R6 cs0 high");
        reg_write(3'd7, 1'b0, 1'b0, 8'hCA);
        expect_mode(2'd0, "R6 cs1 low");
        reg_write(3'd7, 1'b1, 1'b0, 8'h35);
        expect_mode(2'd0, "R6 control block");

        // R3 with C8, exact latency check
        @(negedge clk);
        host_addr = 3'd7; host_cs0_n = 1'b0; host_cs1_n = 1'b1; host_dat = 8'hC8;
        host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_idle();
        expect_mode(2'd0, "R3 not yet after first edge");
        // expect_mode advanced one negedge: the second edge has passed
        checks++;
        #1;
        if (mode !== 2'd1) begin
            errors++;
            $display("FAIL R3 latency: mode=%0d expected mode=1", mode);
        end

        // R10: commands ignored while in DMA read; R8: wrong done ignored
        reg_write(3'd7, 1'b0, 1'b1, 8'hCA);
        expect_mode(2'd1, "R10 write opcode during read");
        pulse_done(1'b0, 1'b1);
        expect_mode(2'd1, "R8 wr_done ignored in read");
        pulse_done(1'b1, 1'b0);
        expect_mode(2'd0, "R8 rd_done releases");

        // R3 with 25
        reg_write(3'd7, 1'b0, 1'b1, 8'h25);
        expect_mode(2'd1, "R3 opcode 25");
        pulse_done(1'b1, 1'b0);
        expect_mode(2'd0, "R8 release again");

        // R4 with CA, R9
        reg_write(3'd7, 1'b0, 1'b1, 8'hCA);
        expect_mode(2'd2, "R4 opcode CA");
        reg_write(3'd7, 1'b0, 1'b1, 8'hC8);
        expect_mode(2'd2, "R10 read opcode during write");
        pulse_done(1'b1, 1'b0);
        expect_mode(2'd2, "R9 rd_done ignored in write");
        pulse_done(1'b0, 1'b1);
        expect_mode(2'd0, "R9 wr_done releases");

        // R4 with 35
        reg_write(3'd7, 1'b0, 1'b1, 8'h35);
        expect_mode(2'd2, "R4 opcode 35");

        // R12: reset from DMA write
        apply_reset();
        expect_mode(2'd0, "R12 reset from dma");

        // R7: opcode changes while strobe low; last value counts
        @(negedge clk);
        host_addr = 3'd7; host_cs0_n = 1'b0; host_cs1_n = 1'b1; host_dat = 8'h00;
        host_wr_n = 1'b0;
        @(negedge clk);
        host_dat = 8'hCA;
        @(negedge clk);
        host_dat = 8'hC8;
        @(negedge clk);
        host_wr_n = 1'b1;
        host_dat  = 8'h35;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_idle();
        expect_mode(2'd1, "R7 last low-phase opcode");
        pulse_done(1'b1, 1'b0);
        expect_mode(2'd0, "R7 release");

        // R7: DMA opcode seen early in the strobe, then replaced
        @(negedge clk);
        host_addr = 3'd7; host_cs0_n = 1'b0; host_cs1_n = 1'b1; host_dat = 8'hCA;
        host_wr_n = 1'b0;
        @(negedge clk);
        host_dat = 8'hEC;
        @(negedge clk);
        host_wr_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_idle();
        expect_mode(2'd0, "R7 early opcode discarded");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule